// File: doc/BRIEF.md
# Off-Delay Timer Channel

This block is one off-delay timer channel. It watches a one-bit rung condition and an external timebase tick strobe. While the rung is true the channel reports enabled and done, and its accumulator stays at zero. When the rung drops, the channel counts ticks up to a programmed preset. Once the preset is reached, the done indication falls.

The accumulator and three status flags (enable, timing, done) are visible at the ports. The flags are packed into a 16-bit control word. A run/hold input freezes the whole channel while the surrounding controller is in program mode. On the first run cycle after a hold, the channel applies a fixed recovery action, and that action depends on the rung level at that moment.

Top module: `offdelay_timer`

## Requirements
- R1: A synchronous active-high reset sets the accumulator to zero and every control-word bit to zero.
- R2: In a run cycle with the rung true, the next state has accumulator 0, EN=1, DN=1 and TT=0. This holds even when a tick arrives or timing has just finished in the same cycle.
- R3: In a run cycle with the rung false and DN set, TT becomes 1. A tick (a clock in which the tick input is 1) raises the accumulator by one while it is below the preset. Without a tick the accumulator holds.
- R4: When a tick leaves the accumulator greater than or equal to the preset, DN and TT clear. The accumulator then stays where it stopped, and later ticks with the rung false leave every output unchanged.
- R5: With a preset of 0, timing completes on the first tick after the rung falls, and the accumulator stays 0.
- R6: EN clears in the first run cycle in which the rung is false.
- R7: While the run input is 0 (hold), the accumulator, EN, TT and DN keep their values whatever the rung and tick inputs do.
- R8: In the first run cycle after a hold with the rung true, TT clears, DN keeps its previous value, EN sets and the accumulator clears. A tick in that cycle is not counted.
- R9: In the first run cycle after a hold with the rung false, TT, DN and EN all clear and the accumulator loads the preset value. A tick in that cycle is not counted.
- R10: Control-word layout: bit 15 is EN, bit 14 is TT, bit 13 is DN. Bits 12 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 = run mode, 0 = hold (program) mode |
| rung_i | input | 1 | Rung condition |
| tick_i | input | 1 | Timebase strobe, one count per clock it is high |
| preset_i | input | 16 | Preset, unsigned |
| acc_o | output | 16 | Accumulator, unsigned |
| ctrl_o | output | 16 | Control word: EN bit 15, TT bit 14, DN bit 13 |

## Verification
Two events can collide with a tick strobe in the same cycle. The first is the recovery action on leaving hold. The bench returns to run with the tick high, once with the rung false and once with the rung true, and expects the recovery values with no count added. The second is the rung rising on the very tick that would finish timing. The bench expects the rung-true clearing to win over completion. A behavioural model in the bench computes the expected accumulator and control word, and the bench compares them with the design on every clock.

// File: rtl/ofd_pkg.sv
package ofd_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD   = 2'd0,
    MODE_RESUME = 2'd1,
    MODE_RUN    = 2'd2
  } run_mode_e;

  localparam int unsigned CTRL_W = 16;
  localparam int unsigned BIT_EN = 15;
  localparam int unsigned BIT_TT = 14;
  localparam int unsigned BIT_DN = 13;
endpackage

// File: rtl/ofd_mode.sv
module ofd_mode
  import ofd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      run_i,
  output run_mode_e mode_o
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b1;
    else     run_q <= run_i;
  end

  always_comb begin
    if (!run_i)     mode_o = MODE_HOLD;
    else if (run_q) mode_o = MODE_RUN;
    else            mode_o = MODE_RESUME;
  end

  // R8/R9: recovery lasts exactly one cycle
  p_resume_single_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_RESUME) |=> (mode_o != MODE_RESUME));
endmodule

// File: rtl/ofd_accum.sv
module ofd_accum
  import ofd_pkg::*;
#(
  parameter int unsigned W = 16
)(
  input  logic         clk,
  input  logic         rst,
  input  run_mode_e    mode_i,
  input  logic         rung_i,
  input  logic         tick_i,
  input  logic         timing_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] acc_o,
  output logic         expire_o
);
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_step;
  logic         below;

  always_comb begin
    below    = acc_q < preset_i;
    acc_step = below ? acc_q + 1'b1 : acc_q;
    expire_o = (mode_i == MODE_RUN) && !rung_i && timing_i && tick_i &&
               (acc_step >= preset_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else begin
      unique case (mode_i)
        MODE_HOLD:   acc_q <= acc_q;
        MODE_RESUME: acc_q <= rung_i ? '0 : preset_i;
        default: begin
          if (rung_i)                acc_q <= '0;
          else if (timing_i && tick_i) acc_q <= acc_step;
        end
      endcase
    end
  end

  assign acc_o = acc_q;

  p_hold_acc_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_HOLD) |=> $stable(acc_q));
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RUN && rung_i) |=> (acc_q == '0));
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RUN && !rung_i && timing_i && tick_i && acc_q < preset_i)
      |=> (acc_q == $past(acc_q) + 1'b1));
  p_load_preset_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RESUME && !rung_i) |=> (acc_q == $past(preset_i)));
endmodule

// File: rtl/ofd_status.sv
module ofd_status
  import ofd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  run_mode_e mode_i,
  input  logic      rung_i,
  input  logic      expire_i,
  output logic      en_o,
  output logic      tt_o,
  output logic      dn_o
);
  logic en_q, tt_q, dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      tt_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      unique case (mode_i)
        MODE_HOLD: begin
          en_q <= en_q;
          tt_q <= tt_q;
          dn_q <= dn_q;
        end
        MODE_RESUME: begin
          en_q <= rung_i;
          tt_q <= 1'b0;
          dn_q <= rung_i ? dn_q : 1'b0;
        end
        default: begin
          if (rung_i) begin
            en_q <= 1'b1;
            dn_q <= 1'b1;
            tt_q <= 1'b0;
          end else begin
            en_q <= 1'b0;
            if (dn_q && !expire_i) begin
              tt_q <= 1'b1;
            end else begin
              tt_q <= 1'b0;
              dn_q <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  assign en_o = en_q;
  assign tt_o = tt_q;
  assign dn_o = dn_q;

  p_en_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RUN && !rung_i) |=> !en_q);
  p_tt_needs_dn_r4: assert property (@(posedge clk) disable iff (rst)
    tt_q |-> (dn_q && !en_q));
  p_resume_true_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RESUME && rung_i) |=> (en_q && !tt_q && dn_q == $past(dn_q)));
  p_hold_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_HOLD) |=> ($stable(en_q) && $stable(tt_q) && $stable(dn_q)));
endmodule

// File: rtl/offdelay_timer.sv
module offdelay_timer
  import ofd_pkg::*;
#(
  parameter int unsigned W = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              rung_i,
  input  logic              tick_i,
  input  logic [W-1:0]      preset_i,
  output logic [W-1:0]      acc_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  run_mode_e mode;
  logic      expire;
  logic      en, tt, dn;

  ofd_mode u_mode (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run_i),
    .mode_o (mode)
  );

  ofd_accum #(.W(W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode),
    .rung_i   (rung_i),
    .tick_i   (tick_i),
    .timing_i (dn),
    .preset_i (preset_i),
    .acc_o    (acc_o),
    .expire_o (expire)
  );

  ofd_status u_status (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode),
    .rung_i   (rung_i),
    .expire_i (expire),
    .en_o     (en),
    .tt_o     (tt),
    .dn_o     (dn)
  );

  always_comb begin
    ctrl_o         = '0;
    ctrl_o[BIT_EN] = en;
    ctrl_o[BIT_TT] = tt;
    ctrl_o[BIT_DN] = dn;
  end

  // R4: once done has fallen in run mode, ticks with the rung low move nothing
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && !rung_i && !dn) |=> ($stable(acc_o) && !ctrl_o[BIT_DN]));
endmodule

// File: tb/test_offdelay_timer.sv
`timescale 1ns/1ps
module test_offdelay_timer;
  logic        clk = 1'b0;
  logic        rst, run_i, rung_i, tick_i;
  logic [15:0] preset_i;
  logic [15:0] acc_o, ctrl_o;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  int m_acc;
  bit m_en, m_tt, m_dn, m_was_run;

  offdelay_timer i_offdelay_timer (
    .clk(clk), .rst(rst), .run_i(run_i), .rung_i(rung_i), .tick_i(tick_i),
    .preset_i(preset_i), .acc_o(acc_o), .ctrl_o(ctrl_o)
  );

  always #4 clk = ~clk;

  task automatic model_step();
    int pre = int'(preset_i);
    if (rst) begin
      m_acc = 0; m_en = 0; m_tt = 0; m_dn = 0; m_was_run = 1;
    end else if (!run_i) begin
      m_was_run = 0;
    end else if (!m_was_run) begin
      m_was_run = 1;
      if (rung_i) begin
        m_en = 1; m_tt = 0; m_acc = 0;
      end else begin
        m_en = 0; m_tt = 0; m_dn = 0; m_acc = pre;
      end
    end else if (rung_i) begin
      m_acc = 0; m_en = 1; m_dn = 1; m_tt = 0;
    end else begin
      m_en = 0;
      if (m_dn) begin
        if (tick_i) begin
          if (m_acc < pre) m_acc = m_acc + 1;
          if (m_acc >= pre) begin m_dn = 0; m_tt = 0; end
          else m_tt = 1;
        end else begin
          m_tt = 1;
        end
      end else begin
        m_tt = 0;
      end
    end
  endtask

  task automatic cyc(input bit r, input bit run, input bit rung, input bit tick,
                     input string tag);
    logic [15:0] exp_ctrl;
    rst = r; run_i = run; rung_i = rung; tick_i = tick;
    @(posedge clk);
    model_step();
    #1;
    exp_ctrl = '0;
    exp_ctrl[15] = m_en; exp_ctrl[14] = m_tt; exp_ctrl[13] = m_dn;
    checks++;
    if (acc_o !== 16'(m_acc)) begin
      errors++;
      $display("FAIL %s acc: actual=%0d expected=%0d", tag, acc_o, m_acc);
    end
    checks++;
    if (ctrl_o !== exp_ctrl) begin
      errors++;
      $display("FAIL %s/R10 ctrl: actual=%h expected=%h", tag, ctrl_o, exp_ctrl);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    preset_i = 16'd5;
    rst = 1; run_i = 1; rung_i = 0; tick_i = 0;
    // R1: reset state
    repeat (3) cyc(1, 1, 1, 1, "R1");
    // R8: leave hold with rung true right after reset, DN keeps 0
    cyc(0, 0, 0, 1, "R7");
    cyc(0, 1, 1, 1, "R8");
    cyc(0, 1, 1, 0, "R2");
    // R3/R4: time out preset 5 with gaps between ticks
    cyc(0, 1, 0, 0, "R6");
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, i[0], "R3");
    for (int i = 0; i < 4; i++)  cyc(0, 1, 0, 1, "R4");
    // R2: rung true in the middle of timing clears the count
    cyc(0, 1, 1, 0, "R2");
    cyc(0, 1, 0, 1, "R3");
    cyc(0, 1, 0, 1, "R3");
    cyc(0, 1, 1, 1, "R2");
    // R2 vs R4: rung rises on the completing tick
    preset_i = 16'd2;
    cyc(0, 1, 0, 1, "R3");
    cyc(0, 1, 1, 1, "R2");
    // R5: preset 0
    preset_i = 16'd0;
    cyc(0, 1, 0, 0, "R5");
    cyc(0, 1, 0, 0, "R5");
    cyc(0, 1, 0, 1, "R5");
    cyc(0, 1, 0, 1, "R5");
    // R7/R9: hold during timing, resume with rung false and tick
    preset_i = 16'd10;
    cyc(0, 1, 1, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 1, "R3");
    for (int i = 0; i < 6; i++) cyc(0, 0, i[0], i[1], "R7");
    preset_i = 16'd7;
    cyc(0, 1, 0, 1, "R9");
    cyc(0, 1, 0, 1, "R4");
    // R8: hold during timing, resume with rung true and tick
    cyc(0, 1, 1, 0, "R2");
    for (int i = 0; i < 2; i++) cyc(0, 1, 0, 1, "R3");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, "R7");
    cyc(0, 1, 1, 1, "R8");
    cyc(0, 1, 0, 1, "R3");
    // R9 with DN already clear, then a reset mid-operation
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 1, "R4");
    cyc(0, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, "R9");
    cyc(0, 1, 1, 0, "R2");
    cyc(1, 1, 0, 1, "R1");
    cyc(0, 1, 0, 1, "R4");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule